// File: doc/BRIEF.md
# Memory Field Extension Controller

This block widens the 12-bit addresses of a small word-oriented CPU so that it can reach up to eight memory fields. Each field is one whole CPU address space. The controller keeps five field registers: the current instruction field, a pending instruction buffer, the data field, a six-bit save register and a break field for DMA. On every memory cycle it drives a 3-bit field extension. The CPU reports the kind of cycle on a two-bit code, and the controller chooses the extension from that code.

Software changes the fields with I/O instructions in device group 62 (octal). A new instruction field is staged in the buffer first. It takes effect at the next jump or subroutine call, so the code that changes the field can still finish the jump that follows it. Until that jump arrives, an interrupt-inhibit output stays high. When an interrupt is acknowledged, the current fields are saved and then cleared. A restore instruction stages them back. A front-panel load writes the registers directly, without going through instruction decode.

Top module: `memfld_ctrl`

## Requirements
- R1: After reset, every field register reads 0 and `intr_inhibit` is 0.
- R2: `ext_field` follows `cyc_kind`. Codes 0 (instruction fetch) and 1 (direct operand) give the instruction field. Code 2 (indirect operand) gives the data field. Code 3 (data break) gives the break field.
- R3: A strobed word with bits 11:6 = 62 (octal) and bits 2:0 = 1 loads bits 5:3 into the data field. Bits 2:0 = 2 loads them into the instruction buffer and leaves the instruction field alone. Bits 2:0 = 3 loads both.
- R4: A jump/call event copies the instruction buffer into the instruction field. When the same edge also carries a buffer load, the copy uses the buffer value from before that load.
- R5: Interrupt acknowledge stores {instruction field, data field} into the save register (instruction field in bits 5:3) and clears the instruction field, the buffer and the data field.
- R6: While a read is strobed, `ac_out` equals `ac_in` ORed with the value placed at a fixed position, counting AC bit 0 as the MSB. Word 6214 places the data field in AC bits 6–8, which are `ac_out[5:3]`. Word 6224 places the instruction field in the same bits. Word 6234 places the save register in AC bits 6–11, which are `ac_out[5:0]`. At all other times `ac_out` equals `ac_in`.
- R7: Word 6244 loads save bits 2:0 into the data field and save bits 5:3 into the instruction buffer.
- R8: Words with bits 2:0 = 2 or 3, and word 6244, raise `intr_inhibit`. It stays high until a jump/call event, an interrupt acknowledge or a panel load clears it.
- R9: `panel_ld` loads `panel_if` into the instruction field and the buffer, `panel_df` into the data field and `panel_bf` into the break field. It takes priority over every other input.
- R10: Strobed words from other device groups, and group-62 words with bits 2:0 = 4 and bits 5:3 outside 1–4, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iot_valid | input | 1 | I/O instruction strobe |
| iot_word | input | 12 | I/O instruction word |
| jump_evt | input | 1 | Jump or subroutine call executed |
| intr_ack | input | 1 | Interrupt acknowledged |
| cyc_kind | input | 2 | Cycle type: 0 fetch, 1 direct, 2 indirect, 3 break |
| panel_ld | input | 1 | Front-panel register load |
| panel_if | input | 3 | Panel instruction field value |
| panel_df | input | 3 | Panel data field value |
| panel_bf | input | 3 | Panel break field value |
| ac_in | input | 12 | Accumulator value from the CPU |
| ac_out | output | 12 | Accumulator value with field bits merged in |
| ext_field | output | 3 | Field extension for the current memory cycle |
| intr_inhibit | output | 1 | Interrupts must be held off |

## Verification
The bench targets these corner cases:

- **Change-instruction-field leaks into fetches.** The bench issues a change-instruction-field and then, before any jump, reads the fetch extension. A design that wrote the instruction field directly would show the new field on fetch cycles right away.
- **Direct operands routed wrongly.** All four cycle kinds are swept after every operation. A mux that sent direct operands through the data field would be caught.
- **Save/restore field order.** The bench uses asymmetric field pairs across interrupt, read-save and restore. A design that swapped the two halves of the save register would return mirrored values.
- **Inhibit and ignored words.** The bench checks that the inhibit stays set across unrelated instructions and falls only on the jump. It also confirms that the wrong device codes leave every field unchanged.

// File: rtl/memfld_pkg.sv
`timescale 1ns/1ps
package memfld_pkg;
  localparam int FIELD_W = 3;
  localparam int WORD_W  = 12;
  localparam int SAVE_W  = 2 * FIELD_W;
  localparam logic [5:0] DEV_CODE = 6'o62;

  typedef enum logic [1:0] {
    CYC_FETCH  = 2'd0,
    CYC_DIRECT = 2'd1,
    CYC_INDIR  = 2'd2,
    CYC_BREAK  = 2'd3
  } cyc_e;

  // place a save-width value in AC bits 6..11 (MSB-first numbering)
  function automatic logic [WORD_W-1:0] ac_place(input logic [SAVE_W-1:0] v);
    ac_place = {{(WORD_W-SAVE_W){1'b0}}, v};
  endfunction

  // field value in AC bits 6..8
  function automatic logic [WORD_W-1:0] ac_field(input logic [FIELD_W-1:0] f);
    ac_field = ac_place({f, {FIELD_W{1'b0}}});
  endfunction
endpackage

// File: rtl/memfld_decode.sv
`timescale 1ns/1ps
module memfld_decode
  import memfld_pkg::*;
(
  input  logic              iot_valid,
  input  logic [WORD_W-1:0] iot_word,
  output logic [FIELD_W-1:0] arg,
  output logic              ld_df,
  output logic              ld_ib,
  output logic              rd_df,
  output logic              rd_if,
  output logic              rd_sf,
  output logic              restore
);
  logic       hit;
  logic [2:0] fn;

  always_comb begin
    hit = iot_valid && (iot_word[11:6] == DEV_CODE);
    fn  = iot_word[2:0];
    arg = iot_word[5:3];
    ld_df   = hit && (fn == 3'd1 || fn == 3'd3);
    ld_ib   = hit && (fn == 3'd2 || fn == 3'd3);
    rd_df   = hit && fn == 3'd4 && arg == 3'd1;
    rd_if   = hit && fn == 3'd4 && arg == 3'd2;
    rd_sf   = hit && fn == 3'd4 && arg == 3'd3;
    restore = hit && fn == 3'd4 && arg == 3'd4;
  end
endmodule

// File: rtl/memfld_regs.sv
`timescale 1ns/1ps
module memfld_regs
  import memfld_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               panel_ld,
  input  logic [FIELD_W-1:0] panel_if,
  input  logic [FIELD_W-1:0] panel_df,
  input  logic [FIELD_W-1:0] panel_bf,
  input  logic               intr_ack,
  input  logic               jump_evt,
  input  logic [FIELD_W-1:0] arg,
  input  logic               ld_df,
  input  logic               ld_ib,
  input  logic               restore,
  output logic [FIELD_W-1:0] if_q,
  output logic [FIELD_W-1:0] ib_q,
  output logic [FIELD_W-1:0] df_q,
  output logic [SAVE_W-1:0]  sf_q,
  output logic [FIELD_W-1:0] bf_q,
  output logic               inh_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_q  <= '0;
      ib_q  <= '0;
      df_q  <= '0;
      sf_q  <= '0;
      bf_q  <= '0;
      inh_q <= 1'b0;
    end else if (panel_ld) begin
      if_q  <= panel_if;
      ib_q  <= panel_if;
      df_q  <= panel_df;
      bf_q  <= panel_bf;
      inh_q <= 1'b0;
    end else if (intr_ack) begin
      sf_q  <= {if_q, df_q};
      if_q  <= '0;
      ib_q  <= '0;
      df_q  <= '0;
      inh_q <= 1'b0;
    end else begin
      if (jump_evt) begin
        if_q  <= ib_q;
        inh_q <= 1'b0;
      end
      if (ld_df)   df_q <= arg;
      if (ld_ib)   ib_q <= arg;
      if (restore) begin
        df_q <= sf_q[FIELD_W-1:0];
        ib_q <= sf_q[SAVE_W-1:FIELD_W];
      end
      if (ld_ib || restore) inh_q <= 1'b1;
    end
  end
endmodule

// File: rtl/memfld_route.sv
`timescale 1ns/1ps
module memfld_route
  import memfld_pkg::*;
(
  input  logic [1:0]         cyc_kind,
  input  logic [FIELD_W-1:0] if_q,
  input  logic [FIELD_W-1:0] df_q,
  input  logic [SAVE_W-1:0]  sf_q,
  input  logic [FIELD_W-1:0] bf_q,
  input  logic               rd_df,
  input  logic               rd_if,
  input  logic               rd_sf,
  input  logic [WORD_W-1:0]  ac_in,
  output logic [WORD_W-1:0]  ac_out,
  output logic [FIELD_W-1:0] ext_field
);
  cyc_e kind;

  always_comb begin
    kind = cyc_e'(cyc_kind);
    unique case (kind)
      CYC_INDIR: ext_field = df_q;
      CYC_BREAK: ext_field = bf_q;
      default:   ext_field = if_q;
    endcase
  end

  always_comb begin
    ac_out = ac_in;
    if (rd_df) ac_out = ac_in | ac_field(df_q);
    if (rd_if) ac_out = ac_in | ac_field(if_q);
    if (rd_sf) ac_out = ac_in | ac_place(sf_q);
  end
endmodule

// File: rtl/memfld_ctrl.sv
`timescale 1ns/1ps
module memfld_ctrl
  import memfld_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iot_valid,
  input  logic [11:0] iot_word,
  input  logic        jump_evt,
  input  logic        intr_ack,
  input  logic [1:0]  cyc_kind,
  input  logic        panel_ld,
  input  logic [2:0]  panel_if,
  input  logic [2:0]  panel_df,
  input  logic [2:0]  panel_bf,
  input  logic [11:0] ac_in,
  output logic [11:0] ac_out,
  output logic [2:0]  ext_field,
  output logic        intr_inhibit
);
  logic [FIELD_W-1:0] arg;
  logic ld_df, ld_ib, rd_df, rd_if, rd_sf, restore;
  logic [FIELD_W-1:0] if_q, ib_q, df_q, bf_q;
  logic [SAVE_W-1:0]  sf_q;
  logic inh_q;

  memfld_decode dec_i (
    .iot_valid(iot_valid), .iot_word(iot_word), .arg(arg),
    .ld_df(ld_df), .ld_ib(ld_ib), .rd_df(rd_df), .rd_if(rd_if),
    .rd_sf(rd_sf), .restore(restore)
  );

  memfld_regs regs_i (
    .clk(clk), .rst_n(rst_n), .panel_ld(panel_ld), .panel_if(panel_if),
    .panel_df(panel_df), .panel_bf(panel_bf), .intr_ack(intr_ack),
    .jump_evt(jump_evt), .arg(arg), .ld_df(ld_df), .ld_ib(ld_ib),
    .restore(restore), .if_q(if_q), .ib_q(ib_q), .df_q(df_q),
    .sf_q(sf_q), .bf_q(bf_q), .inh_q(inh_q)
  );

  memfld_route route_i (
    .cyc_kind(cyc_kind), .if_q(if_q), .df_q(df_q), .sf_q(sf_q),
    .bf_q(bf_q), .rd_df(rd_df), .rd_if(rd_if), .rd_sf(rd_sf),
    .ac_in(ac_in), .ac_out(ac_out), .ext_field(ext_field)
  );

  assign intr_inhibit = inh_q;
endmodule

// File: rtl/memfld_chk.sv
`timescale 1ns/1ps
module memfld_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       jump_evt,
  input logic       intr_ack,
  input logic       panel_ld,
  input logic       ld_df,
  input logic       ld_ib,
  input logic       restore,
  input logic [1:0] cyc_kind,
  input logic [2:0] if_q,
  input logic [2:0] ib_q,
  input logic [2:0] df_q,
  input logic [5:0] sf_q,
  input logic [2:0] ext_field,
  input logic       inh_q
);
  assert_jump_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    jump_evt && !panel_ld && !intr_ack |=> if_q == $past(ib_q));

  assert_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack && !panel_ld |=> sf_q == {$past(if_q), $past(df_q)});

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack && !panel_ld |=> if_q == 3'd0 && ib_q == 3'd0 && df_q == 3'd0);

  assert_inhibit_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ib || restore) && !panel_ld && !intr_ack |=> inh_q);

  assert_inhibit_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jump_evt && !ld_ib && !restore |=> !inh_q);

  assert_df_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_df && !restore && !intr_ack && !panel_ld |=> $stable(df_q));

  assert_route_indir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_kind == 2'd2 |-> ext_field == df_q);
endmodule

bind memfld_ctrl memfld_chk chk_i (
  .clk(clk), .rst_n(rst_n), .jump_evt(jump_evt), .intr_ack(intr_ack),
  .panel_ld(panel_ld), .ld_df(ld_df), .ld_ib(ld_ib), .restore(restore),
  .cyc_kind(cyc_kind), .if_q(if_q), .ib_q(ib_q), .df_q(df_q), .sf_q(sf_q),
  .ext_field(ext_field), .inh_q(inh_q)
);

// File: tb/memfld_ctrl_tb_top.sv
`timescale 1ns/1ps
module memfld_ctrl_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iot_valid = 1'b0;
  logic [11:0] iot_word = '0;
  logic jump_evt = 1'b0;
  logic intr_ack = 1'b0;
  logic [1:0] cyc_kind = '0;
  logic panel_ld = 1'b0;
  logic [2:0] panel_if = '0, panel_df = '0, panel_bf = '0;
  logic [11:0] ac_in = '0;
  logic [11:0] ac_out;
  logic [2:0] ext_field;
  logic intr_inhibit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_if = 0, m_ib = 0, m_df = 0, m_sf = 0, m_bf = 0, m_inh = 0;

  always #(PERIOD/2) clk = ~clk;

  memfld_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .iot_word(iot_word),
    .jump_evt(jump_evt), .intr_ack(intr_ack), .cyc_kind(cyc_kind),
    .panel_ld(panel_ld), .panel_if(panel_if), .panel_df(panel_df),
    .panel_bf(panel_bf), .ac_in(ac_in), .ac_out(ac_out),
    .ext_field(ext_field), .intr_inhibit(intr_inhibit)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  // octal word 62 N F
  function automatic logic [11:0] fw(input int n, input int f);
    return 12'(('o62 << 6) + (n << 3) + f);
  endfunction

  task automatic strobe(input logic [11:0] w);
    @(negedge clk);
    iot_valid = 1'b1; iot_word = w;
    @(negedge clk);
    iot_valid = 1'b0; iot_word = '0;
  endtask

  task automatic peek(input string req, input logic [11:0] w,
                      input logic [11:0] ac, input int exp);
    @(negedge clk);
    iot_valid = 1'b1; iot_word = w; ac_in = ac;
    #1;
    chk(req, int'(ac_out), exp);
    iot_valid = 1'b0; iot_word = '0; ac_in = '0;
  endtask

  task automatic verify();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cyc_kind = 2'(k);
      #1;
      chk("R2", int'(ext_field), (k < 2) ? m_if : (k == 2 ? m_df : m_bf));
    end
    cyc_kind = '0;
    chk("R8", int'(intr_inhibit), m_inh);
    peek("R6 rdf", 12'o6214, 12'o0000, m_df * 8);
    peek("R6 rif", 12'o6224, 12'o0000, m_if * 8);
    peek("R6 rsf", 12'o6234, 12'o0000, m_sf);
  endtask

  task automatic jump();
    @(negedge clk); jump_evt = 1'b1;
    @(negedge clk); jump_evt = 1'b0;
    m_if = m_ib; m_inh = 0;
  endtask

  task automatic ack();
    @(negedge clk); intr_ack = 1'b1;
    @(negedge clk); intr_ack = 1'b0;
    m_sf = m_if * 8 + m_df; m_if = 0; m_ib = 0; m_df = 0; m_inh = 0;
  endtask

  task automatic panel(input int fi, input int fd, input int fb);
    @(negedge clk);
    panel_ld = 1'b1; panel_if = 3'(fi); panel_df = 3'(fd); panel_bf = 3'(fb);
    @(negedge clk);
    panel_ld = 1'b0;
    m_if = fi; m_ib = fi; m_df = fd; m_bf = fb; m_inh = 0;
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    verify();
    chk("R1 inhibit", int'(intr_inhibit), 0);

    // R3 / R4 / R8 sweep of all field values
    for (int n = 0; n < 8; n++) begin
      strobe(fw(n, 1)); m_df = n;
      verify();
      strobe(fw(7 - n, 2)); m_ib = 7 - n; m_inh = 1;
      verify();                       // R3: fetch field unchanged yet
      strobe(12'o6301);               // R10 other device, inhibit holds
      verify();
      jump();                         // R4
      verify();
      strobe(fw(n, 3)); m_df = n; m_ib = n; m_inh = 1;
      verify();
      jump();
      verify();
    end

    // R4 jump and buffer load on the same edge uses the old buffer
    strobe(fw(2, 2)); m_ib = 2; m_inh = 1;
    jump();
    @(negedge clk);
    iot_valid = 1'b1; iot_word = fw(5, 2); jump_evt = 1'b1;
    @(negedge clk);
    iot_valid = 1'b0; iot_word = '0; jump_evt = 1'b0;
    m_if = 2; m_ib = 5; m_inh = 1;
    verify();
    jump();

    // R9 panel load, R2 break field
    for (int n = 0; n < 8; n++) begin
      panel(n, (n + 3) % 8, 7 - n);
      verify();
    end

    // R5 / R7 interrupt save and restore over asymmetric pairs
    for (int a = 0; a < 8; a++) begin
      panel(a, (a * 5 + 1) % 8, a);
      ack();
      verify();
      chk("R5 cleared fetch", int'(ext_field), 0);
      strobe(12'o6244);
      m_df = m_sf % 8; m_ib = m_sf / 8; m_inh = 1;   // R7
      verify();
      jump();
      chk("R7 if restored", m_if, a);
      verify();
    end

    // R6 OR into accumulator with nonzero AC
    panel(5, 3, 1);
    strobe(fw(6, 1)); m_df = 6;
    peek("R6 or df", 12'o6214, 12'o7007, 12'o7067);
    peek("R6 or if", 12'o6224, 12'o0101, 12'o0151);
    ack();
    peek("R6 or sf", 12'o6234, 12'o1200, 12'o1256);
    peek("R6 no read", 12'o6201, 12'o4321, 12'o4321);

    // R10 ignored words leave every register unchanged
    panel(4, 2, 6);
    strobe(12'o6254);
    strobe(12'o6204);
    strobe(12'o6211 & 12'o5777);
    strobe(12'o6000);
    verify();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule